// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block translates outbound 64-bit request addresses using a set of register-programmed windows. Each window holds a 64-bit match value, a 64-bit remap value, a 64-bit mask and a 32-bit actions word. Each 64-bit value is stored as two 32-bit registers. Bit 0 of a window's low match register enables that window.

A request address hits a window when it agrees with the match value on every mask bit above bit 15. Mask bits 15:0 are ignored, so the smallest window is 64 KiB. The lowest-numbered enabled window that hits is used. The address bits covered by the mask come from the remap value, and the remaining bits come from the request address. When no window hits, the address passes through unchanged and the actions come from a separate default register.

A simple write/read port at 16-bit byte offsets programs the windows. The response (hit flag, window index, translated address, actions word) is registered and appears one cycle after the request.

Top module: `owt_xlate`

## Requirements
- R1: After synchronous reset, every mapped register reads back zero, `rsp_valid` is low, and a request misses with actions zero.
- R2: Window w occupies byte offsets 0x4C00 + 0x20*w. Within a window, the word slots are:
  - 0x00: match low
  - 0x04: match high
  - 0x08: remap low
  - 0x0C: remap high
  - 0x10: mask low
  - 0x14: mask high
  - 0x18: actions

  The default actions register is at 0x4CFC. `cfg_rdata` returns the value stored at the `cfg_addr` presented one cycle earlier.
- R3: A window whose match-low bit 0 is clear never hits, whatever its other registers hold.
- R4: An address hits a window when it equals the match value on every mask bit. Mask bits 15:0 are treated as zero regardless of what was written.
- R5: On a hit, the translated address is (remap AND m) OR (address AND NOT m), where m is the mask with bits 15:0 cleared. Bits 15:0 of the address therefore always pass through.
- R6: When several enabled windows hit, the lowest-numbered one supplies the index, the translated address and the actions word.
- R7: On a miss, `rsp_hit` is 0, `rsp_win` is 0, the address is unchanged and `rsp_actions` equals the default actions register. The actions word carries the transaction type in bits 3:0 (0x0 memory, 0x4 I/O, 0x8 config type 0, 0x9 config type 1, 0xC message), and the block passes it through untouched.
- R8: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high.
- R9: A lookup or read that falls in the same cycle as a register write uses the configuration as it stood before that write.
- R10: Writes to unmapped offsets are ignored. This covers slot 0x1C of windows other than the last, offsets with bits 1:0 nonzero, and offsets outside 0x4C00..0x4CFF. Reads of those offsets return zero.
- R11: Writing zero to all seven registers of a window disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 16 | Register byte offset for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the offset presented one cycle earlier |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 3 | Index of the winning window (0 on miss) |
| rsp_addr | output | 64 | Translated address |
| rsp_actions | output | 32 | Actions word of the winning window or the default |

## Verification
A configuration write and an address lookup can land in the same cycle, and so can a read of the very register being written. The bench provokes this in two ways:
- It clears a window's enable bit in the same cycle as a request that hits that window.
- It presents a register's offset for read while writing that register.

The behavioural model evaluates the lookup and the read before applying the write. The response to that request must therefore still show the old hit, and the following request must miss.

// File: rtl/owt_pkg.sv
package owt_pkg;

    localparam int AW      = 64;
    localparam int DW      = 32;
    localparam int GRAN_LG = 16;

    // Address bits a mask is allowed to cover (granule bits forced out)
    localparam logic [AW-1:0] GRAN_KEEP = ~((AW'(1) << GRAN_LG) - AW'(1));

    // Register slots within a window block (word index)
    localparam int SLOT_MATCH_LO = 0;
    localparam int SLOT_MATCH_HI = 1;
    localparam int SLOT_REMAP_LO = 2;
    localparam int SLOT_REMAP_HI = 3;
    localparam int SLOT_MASK_LO  = 4;
    localparam int SLOT_MASK_HI  = 5;
    localparam int SLOT_ACTIONS  = 6;
    localparam int NSLOT         = 7;

    typedef enum logic [3:0] {
        TT_MEM  = 4'h0,
        TT_IO   = 4'h4,
        TT_CFG0 = 4'h8,
        TT_CFG1 = 4'h9,
        TT_MSG  = 4'hC
    } txn_kind_e;

    typedef struct packed {
        logic          hit;
        logic [AW-1:0] addr;
        logic [DW-1:0] act;
    } xlate_t;

    function automatic logic [AW-1:0] remap_addr(input logic [AW-1:0] a,
                                                 input logic [AW-1:0] remap,
                                                 input logic [AW-1:0] mask);
        logic [AW-1:0] m;
        m = mask & GRAN_KEEP;
        return (remap & m) | (a & ~m);
    endfunction

endpackage

// File: rtl/owt_regs.sv
module owt_regs
    import owt_pkg::*;
#(
    parameter int          NUM_WIN   = 8,
    parameter int          REG_AW    = 16,
    parameter int unsigned BASE_ADDR = 32'h4C00,
    parameter int unsigned STRIDE    = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [REG_AW-1:0]             cfg_addr,
    input  logic [DW-1:0]                 cfg_wdata,
    output logic [DW-1:0]                 cfg_rdata,
    output logic [NUM_WIN-1:0]            win_en,
    output logic [NUM_WIN-1:0][AW-1:0]    win_match,
    output logic [NUM_WIN-1:0][AW-1:0]    win_remap,
    output logic [NUM_WIN-1:0][AW-1:0]    win_mask,
    output logic [NUM_WIN-1:0][DW-1:0]    win_act,
    output logic [DW-1:0]                 dflt_act
);

    localparam int          IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int          STRIDE_LG = $clog2(STRIDE);
    localparam int          SLOT_W    = STRIDE_LG - 2;
    localparam int          OFF_W     = STRIDE_LG + IDX_W;
    localparam int unsigned SPAN      = NUM_WIN * STRIDE;

    logic [DW-1:0]     wreg_q [NUM_WIN][NSLOT];
    logic [DW-1:0]     dflt_q;
    logic [DW-1:0]     rdata_q;
    logic [OFF_W-1:0]  off;
    logic [IDX_W-1:0]  dec_win;
    logic [SLOT_W-1:0] dec_slot;
    logic              in_rng;
    logic              sel_win;
    logic              sel_dflt;

    always_comb begin
        off      = OFF_W'(cfg_addr - REG_AW'(BASE_ADDR));
        in_rng   = (32'(cfg_addr) >= BASE_ADDR) && (32'(cfg_addr) < BASE_ADDR + SPAN)
                   && (off[1:0] == 2'b00);
        dec_win  = off[STRIDE_LG +: IDX_W];
        dec_slot = off[2 +: SLOT_W];
        sel_win  = in_rng && (dec_slot < SLOT_W'(NSLOT));
        sel_dflt = in_rng && (dec_slot == SLOT_W'(NSLOT))
                   && (dec_win == IDX_W'(NUM_WIN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NUM_WIN; w++)
                for (int s = 0; s < NSLOT; s++)
                    wreg_q[w][s] <= '0;
            dflt_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (cfg_we && sel_win)
                wreg_q[dec_win][dec_slot] <= cfg_wdata;
            if (cfg_we && sel_dflt)
                dflt_q <= cfg_wdata;
            rdata_q <= sel_win  ? wreg_q[dec_win][dec_slot] :
                       sel_dflt ? dflt_q : '0;
        end
    end

    always_comb begin
        for (int w = 0; w < NUM_WIN; w++) begin
            win_en[w]    = wreg_q[w][SLOT_MATCH_LO][0];
            win_match[w] = {wreg_q[w][SLOT_MATCH_HI], wreg_q[w][SLOT_MATCH_LO]};
            win_remap[w] = {wreg_q[w][SLOT_REMAP_HI], wreg_q[w][SLOT_REMAP_LO]};
            win_mask[w]  = {wreg_q[w][SLOT_MASK_HI],  wreg_q[w][SLOT_MASK_LO]};
            win_act[w]   = wreg_q[w][SLOT_ACTIONS];
        end
    end

    assign dflt_act  = dflt_q;
    assign cfg_rdata = rdata_q;

endmodule

// File: rtl/owt_match.sv
module owt_match
    import owt_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic [NUM_WIN-1:0]         win_en,
    input  logic [NUM_WIN-1:0][AW-1:0] win_match,
    input  logic [NUM_WIN-1:0][AW-1:0] win_mask,
    input  logic [AW-1:0]              addr,
    output logic [NUM_WIN-1:0]         hit
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        assign hit[g] = win_en[g] &&
                        (((addr ^ win_match[g]) & win_mask[g] & GRAN_KEEP) == '0);
    end

endmodule

// File: rtl/owt_pick.sv
module owt_pick
    import owt_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_WIN-1:0]         hit,
    input  logic [NUM_WIN-1:0][AW-1:0] win_remap,
    input  logic [NUM_WIN-1:0][AW-1:0] win_mask,
    input  logic [NUM_WIN-1:0][DW-1:0] win_act,
    input  logic [DW-1:0]              dflt_act,
    input  logic [AW-1:0]              addr,
    output logic [NUM_WIN-1:0]         gnt,
    output logic [IDX_W-1:0]           idx,
    output xlate_t                     res
);

    logic [AW-1:0] sel_remap;
    logic [AW-1:0] sel_mask;
    logic [DW-1:0] sel_act;

    // Lowest set bit wins
    assign gnt = hit & ~(hit - NUM_WIN'(1));

    always_comb begin
        sel_remap = '0;
        sel_mask  = '0;
        sel_act   = '0;
        idx       = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (gnt[i]) begin
                sel_remap = sel_remap | win_remap[i];
                sel_mask  = sel_mask  | win_mask[i];
                sel_act   = sel_act   | win_act[i];
                idx       = idx       | IDX_W'(i);
            end
        end
        res.hit  = |hit;
        res.addr = res.hit ? remap_addr(addr, sel_remap, sel_mask) : addr;
        res.act  = res.hit ? sel_act : dflt_act;
    end

endmodule

// File: rtl/owt_xlate.sv
module owt_xlate
    import owt_pkg::*;
#(
    parameter int          NUM_WIN   = 8,
    parameter int          REG_AW    = 16,
    parameter int unsigned BASE_ADDR = 32'h4C00,
    parameter int unsigned STRIDE    = 32,
    localparam int         IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_win,
    output logic [AW-1:0]     rsp_addr,
    output logic [DW-1:0]     rsp_actions
);

    logic [NUM_WIN-1:0]         win_en;
    logic [NUM_WIN-1:0][AW-1:0] win_match;
    logic [NUM_WIN-1:0][AW-1:0] win_remap;
    logic [NUM_WIN-1:0][AW-1:0] win_mask;
    logic [NUM_WIN-1:0][DW-1:0] win_act;
    logic [DW-1:0]              dflt_act;
    logic [NUM_WIN-1:0]         match_hit;
    logic [NUM_WIN-1:0]         pick_gnt;
    logic [IDX_W-1:0]           pick_idx;
    xlate_t                     pick_res;

    logic                       vld_q;
    logic [IDX_W-1:0]           win_q;
    xlate_t                     res_q;

    owt_regs #(
        .NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE)
    ) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .win_en(win_en), .win_match(win_match), .win_remap(win_remap),
        .win_mask(win_mask), .win_act(win_act), .dflt_act(dflt_act)
    );

    owt_match #(.NUM_WIN(NUM_WIN)) u_match (
        .win_en(win_en), .win_match(win_match), .win_mask(win_mask),
        .addr(req_addr), .hit(match_hit)
    );

    owt_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_pick (
        .hit(match_hit), .win_remap(win_remap), .win_mask(win_mask),
        .win_act(win_act), .dflt_act(dflt_act), .addr(req_addr),
        .gnt(pick_gnt), .idx(pick_idx), .res(pick_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            win_q <= '0;
            res_q <= '0;
        end else begin
            vld_q <= req_valid;
            win_q <= pick_idx;
            res_q <= pick_res;
        end
    end

    assign rsp_valid   = vld_q;
    assign rsp_hit     = res_q.hit;
    assign rsp_win     = win_q;
    assign rsp_addr    = res_q.addr;
    assign rsp_actions = res_q.act;

endmodule

// File: rtl/owt_xlate_chk.sv
module owt_xlate_chk
    import owt_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [AW-1:0]      req_addr,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [IDX_W-1:0]   rsp_win,
    input logic [AW-1:0]      rsp_addr,
    input logic [NUM_WIN-1:0] win_en,
    input logic [NUM_WIN-1:0] match_hit,
    input logic [NUM_WIN-1:0] pick_gnt
);

    // R8
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R8
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R7
    miss_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == $past(req_addr)));

    // R7
    miss_win_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_win == '0));

    // R5
    granule_keep_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_addr[GRAN_LG-1:0] == $past(req_addr[GRAN_LG-1:0])));

    // R6
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pick_gnt));

    // R6
    hit_agree_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit == $past(|match_hit)));

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_en
        // R3
        disabled_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
            !win_en[g] |-> !match_hit[g]);
    end

endmodule

bind owt_xlate owt_xlate_chk #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_addr(rsp_addr),
    .win_en(win_en), .match_hit(match_hit), .pick_gnt(pick_gnt)
);

// File: tb/sim_owt_xlate.sv
module sim_owt_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [2:0]  rsp_win;
    logic [63:0] rsp_addr;
    logic [31:0] rsp_actions;

    always #5 clk = ~clk;

    owt_xlate u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_win(rsp_win), .rsp_addr(rsp_addr), .rsp_actions(rsp_actions)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;
    bit    started = 0;
    string cur_req = "R1";

    // ---------------- reference model ----------------
    logic [31:0] m_reg [8][7];
    logic [31:0] m_dflt;
    logic        e_valid, e_hit;
    logic [2:0]  e_win;
    logic [63:0] e_addr;
    logic [31:0] e_act, e_rdata;

    // returns window*8+slot for a mapped window word, 100 for default, -1 otherwise
    function automatic int m_decode(input logic [15:0] a);
        int off;
        if (a < 16'h4C00 || a > 16'h4CFF || a[1:0] != 2'b00) return -1;
        off = int'(a) - 'h4C00;
        if ((off % 32) / 4 < 7) return (off / 32) * 8 + (off % 32) / 4;
        if (off / 32 == 7) return 100;
        return -1;
    endfunction

    function automatic logic [31:0] m_read(input logic [15:0] a);
        int d;
        d = m_decode(a);
        if (d == 100) return m_dflt;
        if (d < 0) return 32'h0;
        return m_reg[d / 8][d % 8];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < 8; w++)
                for (int s = 0; s < 7; s++) m_reg[w][s] = '0;
            m_dflt = '0;
            {e_valid, e_hit, e_win, e_addr, e_act, e_rdata} = '0;
        end else begin
            int found;
            logic [63:0] mk, mt, rm;
            e_rdata = m_read(cfg_addr);
            e_valid = req_valid;
            found = -1;
            for (int w = 0; w < 8; w++) begin
                mt = {m_reg[w][1], m_reg[w][0]};
                mk = {m_reg[w][5], m_reg[w][4]} & ~64'hFFFF;
                if (found < 0 && m_reg[w][0][0] && ((req_addr ^ mt) & mk) == 64'h0)
                    found = w;
            end
            if (found >= 0) begin
                mk = {m_reg[found][5], m_reg[found][4]} & ~64'hFFFF;
                rm = {m_reg[found][3], m_reg[found][2]};
                e_hit  = 1'b1;
                e_win  = 3'(found);
                e_addr = (rm & mk) | (req_addr & ~mk);
                e_act  = m_reg[found][6];
            end else begin
                e_hit  = 1'b0;
                e_win  = 3'd0;
                e_addr = req_addr;
                e_act  = m_dflt;
            end
            if (cfg_we) begin
                int d;
                d = m_decode(cfg_addr);
                if (d == 100) m_dflt = cfg_wdata;
                else if (d >= 0) m_reg[d / 8][d % 8] = cfg_wdata;
            end
        end
        started = 1;
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk("cfg_rdata", 64'(cfg_rdata), 64'(e_rdata));
            chk("rsp_valid", 64'(rsp_valid), 64'(e_valid));
            if (e_valid) begin
                chk("rsp_hit", 64'(rsp_hit), 64'(e_hit));
                chk("rsp_win", 64'(rsp_win), 64'(e_win));
                chk("rsp_addr", rsp_addr, e_addr);
                chk("rsp_actions", 64'(rsp_actions), 64'(e_act));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        cfg_addr = a;
        @(negedge clk);
    endtask

    task automatic rq(input logic [63:0] a);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_win(input int w, input logic [63:0] mt, input logic [63:0] rm,
                           input logic [63:0] mk, input logic [31:0] act);
        logic [15:0] b;
        b = 16'h4C00 + 16'(w * 32);
        wr(b + 16'h00, mt[31:0]);  wr(b + 16'h04, mt[63:32]);
        wr(b + 16'h08, rm[31:0]);  wr(b + 16'h0C, rm[63:32]);
        wr(b + 16'h10, mk[31:0]);  wr(b + 16'h14, mk[63:32]);
        wr(b + 16'h18, act);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk("rsp_valid in reset", 64'(rsp_valid), 64'h0);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) rd(16'h4C00 + 16'(i * 36));
        rd(16'h4CFC);
        rq(64'hDEAD_BEEF_1234_5678);
        rd(16'h4C00);

        // R2: register map and readback
        cur_req = "R2";
        set_win(5, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888,
                64'h9999_AAAA_BBBB_CCCC, 32'hDDDD_EEEE);
        wr(16'h4CFC, 32'h0000_0004);
        for (int s = 0; s < 7; s++) rd(16'h4CA0 + 16'(s * 4));
        rd(16'h4CFC);
        set_win(5, 64'h0, 64'h0, 64'h0, 32'h0);

        // R10: unmapped offsets ignored
        cur_req = "R10";
        wr(16'h4CDC, 32'hFFFF_FFFF);
        wr(16'h4C02, 32'hFFFF_FFFF);
        wr(16'h4D00, 32'hFFFF_FFFF);
        wr(16'h4BFC, 32'hFFFF_FFFF);
        rd(16'h4CDC); rd(16'h4C00); rd(16'h4C02); rd(16'h4D00); rd(16'h4BFC);
        rq(64'hFFFF_FFFF_FFFF_0000);
        rd(16'h4C00);

        // R4: 64 KiB granule, mask low bits ignored
        cur_req = "R4";
        set_win(0, 64'h0000_0000_E800_0001, 64'h0000_0000_0000_0000,
                64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0004);
        rq(64'h0000_0000_E800_1234);
        rq(64'h0000_0000_E800_FFFF);
        rq(64'h0000_0000_E801_0000);
        rq(64'h0000_0001_E800_0000);

        // R3: disabled window never hits
        cur_req = "R3";
        set_win(1, 64'h0000_0002_0000_0000, 64'h0000_0000_4000_0000,
                64'hFFFF_FFFF_FFF0_0000, 32'h0000_0008);
        rq(64'h0000_0002_0000_8000);

        // R5: remap with a 1 MiB window and high remap bits
        cur_req = "R5";
        set_win(2, 64'h0000_0001_0000_0001, 64'h0000_ABCD_1230_0000,
                64'hFFFF_FFFF_FFF0_0000, 32'h0080_0F09);
        rq(64'h0000_0001_000A_BCDE);
        rq(64'h0000_0001_000F_FFFF);
        rq(64'h0000_0001_0010_0000);

        // R6: overlap, lowest index wins
        cur_req = "R6";
        set_win(3, 64'h0000_0001_0000_0001, 64'h0000_0000_9900_0000,
                64'hFFFF_FFFF_FF00_0000, 32'h0000_000C);
        rq(64'h0000_0001_0005_0000);
        rq(64'h0000_0001_0080_0000);
        wr(16'h4C40, 32'h0);
        rq(64'h0000_0001_0005_0000);
        wr(16'h4C40, 32'h0000_0001);
        rq(64'h0000_0001_0005_0000);

        // R7: miss uses default actions and passes address through
        cur_req = "R7";
        wr(16'h4CFC, 32'h0000_0009);
        rq(64'h7777_0000_0000_4321);
        rq(64'h0000_0000_0000_0000);

        // R8: response cadence, back-to-back and gaps
        cur_req = "R8";
        req_valid = 1'b1; req_addr = 64'h0000_0000_E800_0010;
        @(negedge clk);
        req_addr = 64'h0000_0001_0001_0000;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);

        // R9: write and lookup/read in the same cycle
        cur_req = "R9";
        cfg_we = 1'b1; cfg_addr = 16'h4C00; cfg_wdata = 32'h0;
        req_valid = 1'b1; req_addr = 64'h0000_0000_E800_0040;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        wr(16'h4C00, 32'hE800_0001);
        rq(64'h0000_0000_E800_0040);

        // R11: zero all registers of a window disables it
        cur_req = "R11";
        set_win(2, 64'h0, 64'h0, 64'h0, 32'h0);
        rq(64'h0000_0001_000A_BCDE);
        set_win(3, 64'h0, 64'h0, 64'h0, 32'h0);
        rq(64'h0000_0001_000A_BCDE);

        // R6: mixed traffic across remaining windows
        cur_req = "R6";
        set_win(4, 64'h0000_0000_E800_0001, 64'h0000_00F0_0000_0000,
                64'hFFFF_FFFF_FF00_0000, 32'h0000_0108);
        set_win(7, 64'h0000_0000_0000_0001, 64'h0000_0000_8000_0000,
                64'hFFFF_FFFF_F000_0000, 32'h4000_0004);
        for (int i = 0; i < 300; i++) begin
            logic [63:0] base;
            case ($urandom % 4)
                0: base = 64'h0000_0000_E800_0000;
                1: base = 64'h0000_0000_0000_0000;
                2: base = 64'h0000_0001_0000_0000;
                default: base = {$urandom, $urandom};
            endcase
            req_valid = ($urandom % 3) != 0;
            req_addr  = base | 64'($urandom % 32'h0200_0000);
            cfg_addr  = 16'h4C00 + 16'($urandom % 256);
            @(negedge clk);
        end
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule